// File: doc/BRIEF.md
# I/Q Sample Pairing Unit

This block sits at the parallel sample input of a dual-channel transmit datapath. It accepts 16-bit baseband words and delivers aligned in-phase/quadrature pairs to the filters that follow. There are two capture modes. In dual-port mode the I word and the Q word arrive on two ports in the same clock cycle. In single-port mode they arrive one after the other on the first port, one word per clock, which is twice the pair rate. In single-port mode a select pin tags each word as I or Q, and an invert control can reverse that tag.

An ordering control sets how interleaved words are grouped. With I-first pairing, an I word is joined with the Q word that follows it. With Q-first pairing, an I word is joined with the Q word received before it. Each word can be converted from offset binary to two's complement as it is captured. A real-only control forces the Q output to zero.

Any change of a mode input discards a partly built pair, so the stream restarts cleanly. Two words with the same tag in a row set a sticky flag, which stays set until it is cleared.

Top module: `iq_pair_assembler`

## Requirements
- R1: With `single_port_i`=0 and no mode change, every clock edge captures I from `port_a_i` and Q from `port_b_i`. `pair_valid_o` is 1 in the following cycle, with the converted words on `i_o`/`q_o`.
- R2: With `single_port_i`=1, one word per clock edge is taken from `port_a_i`. `port_b_i` is ignored. With I-first pairing, an I word followed by a Q word produces the pair (I,Q) in the cycle after the Q edge.
- R3: A word is tagged I when `sel_i` XOR `sel_inv_i` is 1, and tagged Q when it is 0.
- R4: With `q_first_i`=1, a Q word is held until the next I word arrives. That I edge then produces the pair (I, held Q). No pair is produced while only the Q is held.
- R5: With `offset_bin_i`=1, bit 15 of each captured word is inverted. With `offset_bin_i`=0, words pass through unchanged.
- R6: With `real_only_i`=1, every emitted pair has `q_o`=0.
- R7: While `rst_ni` is low, `pair_valid_o`, `tag_err_o`, `i_o` and `q_o` are 0. The mode state resets to all controls 0.
- R8: In single-port mode, `pair_valid_o` is never high in two consecutive cycles.
- R9: In single-port mode, a word whose tag equals the tag of the previous word replaces any held word of that tag and sets `tag_err_o` after that edge. `err_clr_i` clears the flag on the next edge. A new repeat in the same cycle wins over the clear.
- R10: On an edge where any mode input differs from its value at the previous edge, the word on that edge is discarded, any held word and tag history are dropped, and `pair_valid_o` is 0 in the next cycle.
- R11: A word with no partner is dropped without a pair: a Q word with nothing held in I-first mode, or an I word with nothing held in Q-first mode. `i_o`/`q_o` keep the last pair between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| single_port_i | input | 1 | 1: interleaved words on port A; 0: parallel ports |
| sel_inv_i | input | 1 | Reverses the meaning of the tag pin |
| q_first_i | input | 1 | 1: pair each I with the preceding Q |
| offset_bin_i | input | 1 | 1: input words are offset binary |
| real_only_i | input | 1 | 1: Q output forced to zero |
| err_clr_i | input | 1 | Clears the sticky tag error |
| sel_i | input | 1 | I/Q tag of the word on port A |
| port_a_i | input | 16 | I word (dual) or interleaved word (single) |
| port_b_i | input | 16 | Q word in dual-port mode |
| i_o | output | 16 | Paired I sample, two's complement |
| q_o | output | 16 | Paired Q sample, two's complement |
| pair_valid_o | output | 1 | One-cycle strobe per completed pair |
| tag_err_o | output | 1 | Sticky flag: two consecutive words had the same tag |

## Verification
A held word that is wrong, stale or not flushed shows up one cycle after the next completing word. It appears as a wrong partner on `i_o`/`q_o`, or as an extra or missing `pair_valid_o` strobe, which the scoreboard detects because it expects a pair for every completing word and none otherwise. Broken tag history appears on `tag_err_o` one cycle after the repeated word, and the bench reads the flag directly at that point. Errors in the format or real-only handling appear in the very next pair. The streams therefore place offset-binary and real-only words right after mode switches.

// File: rtl/iq_pair_pkg.sv
package iq_pair_pkg;
  localparam int unsigned SAMPLE_W = 16;
  localparam int unsigned N_LANES  = 2;

  typedef struct packed {
    logic single_port;
    logic sel_inv;
    logic q_first;
    logic offset_bin;
    logic real_only;
  } mode_t;
endpackage

// File: rtl/iq_fmt_conv.sv
module iq_fmt_conv #(
  parameter int unsigned W = 16
) (
  input  logic         offset_bin_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] word_o
);
  // offset binary -> two's complement is a sign-bit flip
  assign word_o = {word_i[W-1] ^ offset_bin_i, word_i[W-2:0]};
endmodule

// File: rtl/iq_interleave.sv
module iq_interleave #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         flush_i,
  input  logic         q_first_i,
  input  logic         is_i_i,
  input  logic [W-1:0] word_i,
  output logic         emit_o,
  output logic [W-1:0] i_o,
  output logic [W-1:0] q_o,
  output logic         dup_o
);
  logic         hold_vld_q;
  logic [W-1:0] hold_word_q;
  logic         last_vld_q;
  logic         last_is_i_q;
  logic         active;
  logic         is_opener;

  assign active    = en_i && !flush_i;
  // opener: the word type that waits for a partner
  assign is_opener = (is_i_i != q_first_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_vld_q  <= 1'b0;
      hold_word_q <= '0;
      last_vld_q  <= 1'b0;
      last_is_i_q <= 1'b0;
    end else if (!active) begin
      hold_vld_q <= 1'b0;
      last_vld_q <= 1'b0;
    end else begin
      last_vld_q  <= 1'b1;
      last_is_i_q <= is_i_i;
      if (is_opener) begin
        hold_word_q <= word_i;
        hold_vld_q  <= 1'b1;
      end else begin
        hold_vld_q <= 1'b0;
      end
    end
  end

  assign emit_o = active && hold_vld_q && !is_opener;
  assign i_o    = q_first_i ? word_i : hold_word_q;
  assign q_o    = q_first_i ? hold_word_q : word_i;
  assign dup_o  = active && last_vld_q && (last_is_i_q == is_i_i);
endmodule

// File: rtl/iq_pair_out.sv
module iq_pair_out #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         dual_emit_i,
  input  logic [W-1:0] dual_i_i,
  input  logic [W-1:0] dual_q_i,
  input  logic         ser_emit_i,
  input  logic [W-1:0] ser_i_i,
  input  logic [W-1:0] ser_q_i,
  input  logic         real_only_i,
  input  logic         dup_i,
  input  logic         err_clr_i,
  output logic [W-1:0] i_o,
  output logic [W-1:0] q_o,
  output logic         pair_valid_o,
  output logic         tag_err_o
);
  logic         emit;
  logic [W-1:0] nxt_i, nxt_q;

  assign emit  = dual_emit_i || ser_emit_i;
  assign nxt_i = dual_emit_i ? dual_i_i : ser_i_i;
  assign nxt_q = real_only_i ? '0 : (dual_emit_i ? dual_q_i : ser_q_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i_o          <= '0;
      q_o          <= '0;
      pair_valid_o <= 1'b0;
      tag_err_o    <= 1'b0;
    end else begin
      pair_valid_o <= emit;
      if (emit) begin
        i_o <= nxt_i;
        q_o <= nxt_q;
      end
      if (dup_i)          tag_err_o <= 1'b1;
      else if (err_clr_i) tag_err_o <= 1'b0;
    end
  end
endmodule

// File: rtl/iq_pair_assembler.sv
module iq_pair_assembler
  import iq_pair_pkg::*;
#(
  parameter int unsigned W = SAMPLE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         single_port_i,
  input  logic         sel_inv_i,
  input  logic         q_first_i,
  input  logic         offset_bin_i,
  input  logic         real_only_i,
  input  logic         err_clr_i,
  input  logic         sel_i,
  input  logic [W-1:0] port_a_i,
  input  logic [W-1:0] port_b_i,
  output logic [W-1:0] i_o,
  output logic [W-1:0] q_o,
  output logic         pair_valid_o,
  output logic         tag_err_o
);
  mode_t        mode_in, mode_q;
  logic         mode_chg;
  logic [W-1:0] raw  [N_LANES];
  logic [W-1:0] conv [N_LANES];
  logic         ser_emit, dup;
  logic [W-1:0] ser_i, ser_q;

  assign mode_in = '{single_port: single_port_i, sel_inv: sel_inv_i,
                     q_first: q_first_i, offset_bin: offset_bin_i,
                     real_only: real_only_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= '0;
    else         mode_q <= mode_in;
  end

  assign mode_chg = (mode_in != mode_q);

  assign raw[0] = port_a_i;
  assign raw[1] = port_b_i;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    iq_fmt_conv #(.W(W)) u_conv (
      .offset_bin_i (offset_bin_i),
      .word_i       (raw[g]),
      .word_o       (conv[g])
    );
  end

  iq_interleave #(.W(W)) u_ilv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (single_port_i),
    .flush_i   (mode_chg),
    .q_first_i (q_first_i),
    .is_i_i    (sel_i ^ sel_inv_i),
    .word_i    (conv[0]),
    .emit_o    (ser_emit),
    .i_o       (ser_i),
    .q_o       (ser_q),
    .dup_o     (dup)
  );

  iq_pair_out #(.W(W)) u_out (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dual_emit_i  (!single_port_i && !mode_chg),
    .dual_i_i     (conv[0]),
    .dual_q_i     (conv[1]),
    .ser_emit_i   (ser_emit),
    .ser_i_i      (ser_i),
    .ser_q_i      (ser_q),
    .real_only_i  (real_only_i),
    .dup_i        (dup),
    .err_clr_i    (err_clr_i),
    .i_o          (i_o),
    .q_o          (q_o),
    .pair_valid_o (pair_valid_o),
    .tag_err_o    (tag_err_o)
  );
endmodule

// File: rtl/iq_pair_assembler_chk.sv
module iq_pair_assembler_chk
  import iq_pair_pkg::*;
#(
  parameter int unsigned W = SAMPLE_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         single_port_i,
  input logic         sel_inv_i,
  input logic         q_first_i,
  input logic         offset_bin_i,
  input logic         real_only_i,
  input logic         err_clr_i,
  input logic [W-1:0] port_a_i,
  input logic [W-1:0] port_b_i,
  input logic [W-1:0] i_o,
  input logic [W-1:0] q_o,
  input logic         pair_valid_o,
  input logic         tag_err_o,
  input mode_t        mode_q
);
  logic changed;
  assign changed = ({single_port_i, sel_inv_i, q_first_i, offset_bin_i, real_only_i}
                    != mode_q);

  always @(posedge clk_i)
    if (!rst_ni) assert_reset_R7: assert (!pair_valid_o && !tag_err_o && i_o == '0);

  assert_dual_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!single_port_i && !changed) |=> (pair_valid_o &&
      i_o == ($past(port_a_i) ^ {$past(offset_bin_i), {(W-1){1'b0}}})));

  assert_dual_q_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!single_port_i && !changed && !real_only_i) |=>
      (q_o == ($past(port_b_i) ^ {$past(offset_bin_i), {(W-1){1'b0}}})));

  assert_real_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_valid_o && mode_q.real_only) |-> (q_o == '0));

  assert_spacing_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_valid_o && mode_q.single_port) |=> !pair_valid_o);

  assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_err_o && !err_clr_i) |=> tag_err_o);

  assert_flush_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    changed |=> !pair_valid_o);
endmodule

bind iq_pair_assembler iq_pair_assembler_chk #(.W(W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .single_port_i (single_port_i),
  .sel_inv_i     (sel_inv_i),
  .q_first_i     (q_first_i),
  .offset_bin_i  (offset_bin_i),
  .real_only_i   (real_only_i),
  .err_clr_i     (err_clr_i),
  .port_a_i      (port_a_i),
  .port_b_i      (port_b_i),
  .i_o           (i_o),
  .q_o           (q_o),
  .pair_valid_o  (pair_valid_o),
  .tag_err_o     (tag_err_o),
  .mode_q        (mode_q)
);

// File: tb/sim_iq_pair_assembler.sv
module sim_iq_pair_assembler;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sp = 1'b1, inv = 1'b0, qf = 1'b0, ob = 1'b0, ro = 1'b0, clr = 1'b0, sel = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic [15:0] i_o, q_o;
  logic pv, err;
  int n_run = 0, n_fail = 0;

  typedef struct { logic [15:0] i; logic [15:0] q; string tag; } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  iq_pair_assembler u0 (
    .clk_i(clk), .rst_ni(rst_n), .single_port_i(sp), .sel_inv_i(inv),
    .q_first_i(qf), .offset_bin_i(ob), .real_only_i(ro), .err_clr_i(clr),
    .sel_i(sel), .port_a_i(a), .port_b_i(b),
    .i_o(i_o), .q_o(q_o), .pair_valid_o(pv), .tag_err_o(err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] ei, input logic [15:0] eq, input string tag);
    exp_t e;
    e.i = ei; e.q = eq; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic step(input logic [15:0] wa, input logic [15:0] wb, input logic s,
                      input logic c = 1'b0);
    @(negedge clk);
    a = wa; b = wb; sel = s; clr = c;
  endtask

  task automatic set_mode(input logic m_sp, input logic m_inv, input logic m_qf,
                          input logic m_ob, input logic m_ro);
    @(negedge clk);
    sp = m_sp; inv = m_inv; qf = m_qf; ob = m_ob; ro = m_ro;
    a = 16'h0; b = 16'h0; sel = 1'b0; clr = 1'b0;
  endtask

  task automatic wait_out();
    @(posedge clk);
    #1;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && pv) begin
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R10/R11 unexpected pair act=%h/%h exp=none", i_o, q_o);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (i_o !== e.i || q_o !== e.q) begin
          n_fail++;
          $display("FAIL %s pair act=%h/%h exp=%h/%h", e.tag, i_o, q_o, e.i, e.q);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 reset pv", pv, 0);
    chk("R7 reset err", err, 0);
    chk("R7 reset i", i_o, 0);
    chk("R7 reset q", q_o, 0);
    rst_n = 1'b1;

    // R1 dual port
    set_mode(0, 0, 0, 0, 0);
    step(16'h1234, 16'hABCD, 0); push(16'h1234, 16'hABCD, "R1");
    wait_out(); chk("R1 pv", pv, 1);
    step(16'h0F0F, 16'hF0F0, 1); push(16'h0F0F, 16'hF0F0, "R1");
    step(16'h7FFF, 16'h8000, 0); push(16'h7FFF, 16'h8000, "R1");
    wait_out(); chk("R1 i", i_o, 16'h7FFF);

    // R5 offset binary, dual
    set_mode(0, 0, 0, 1, 0);
    wait_out(); chk("R10 dual flush pv", pv, 0);
    step(16'h8001, 16'h7FFF, 0); push(16'h0001, 16'hFFFF, "R5");
    // R6 real only, dual
    set_mode(0, 0, 0, 0, 1);
    step(16'h1111, 16'h5678, 0); push(16'h1111, 16'h0000, "R6");
    wait_out(); chk("R6 q zero", q_o, 0);

    // R2/R8 single port I-first
    set_mode(1, 0, 0, 0, 0);
    step(16'h1111, 16'hDEAD, 1);
    wait_out(); chk("R8 no pair after I", pv, 0);
    step(16'h2222, 16'hBEEF, 0); push(16'h1111, 16'h2222, "R2");
    wait_out(); chk("R2 pv after Q", pv, 1);
    step(16'h3333, 16'h0000, 1);
    wait_out(); chk("R8 gap", pv, 0);
    step(16'h4444, 16'h0000, 0); push(16'h3333, 16'h4444, "R2");
    wait_out(); chk("R9 no err", err, 0);

    // R3 inverted select
    set_mode(1, 1, 0, 0, 0);
    step(16'hAAAA, 16'h0, 0);
    step(16'hBBBB, 16'h0, 1); push(16'hAAAA, 16'hBBBB, "R3");
    wait_out(); chk("R3 q", q_o, 16'hBBBB);

    // R4 Q-first
    set_mode(1, 0, 1, 0, 0);
    step(16'h0010, 16'h0, 1);
    wait_out(); chk("R11 orphan I", pv, 0);
    step(16'h0100, 16'h0, 0);
    wait_out(); chk("R4 Q waits", pv, 0);
    step(16'h0011, 16'h0, 1); push(16'h0011, 16'h0100, "R4");
    step(16'h0101, 16'h0, 0);
    step(16'h0012, 16'h0, 1); push(16'h0012, 16'h0101, "R4");
    wait_out(); chk("R4 i", i_o, 16'h0012);

    // R11 orphan Q, hold, then R9 repeats
    set_mode(1, 0, 0, 0, 0);
    step(16'h5555, 16'h0, 0);
    step(16'h6666, 16'h0, 1);
    step(16'h7777, 16'h0, 0); push(16'h6666, 16'h7777, "R11");
    step(16'h9999, 16'h0, 1);
    wait_out(); chk("R11 hold i", i_o, 16'h6666);
    step(16'hAAAA, 16'h0, 1);
    step(16'hBBBB, 16'h0, 0); push(16'hAAAA, 16'hBBBB, "R9");
    wait_out(); chk("R9 err set", err, 1);
    step(16'hCCCC, 16'h0, 1, 1);
    wait_out(); chk("R9 err clr", err, 0);
    step(16'hDDDD, 16'h0, 1, 1);
    wait_out(); chk("R9 set wins", err, 1);
    step(16'hEEEE, 16'h0, 0, 1); push(16'hDDDD, 16'hEEEE, "R9");
    wait_out(); chk("R9 err clr2", err, 0);

    // R10 flush of held I, with R5 in single mode
    step(16'h1357, 16'h0, 1);
    set_mode(1, 0, 0, 1, 0);
    step(16'h8000, 16'h0, 0);
    wait_out(); chk("R10 held I dropped", pv, 0);
    step(16'h8001, 16'h0, 1);
    step(16'h0002, 16'h0, 0); push(16'h0001, 16'h8002, "R5");
    wait_out(); chk("R5 q", q_o, 16'h8002);

    // R6 single real
    set_mode(1, 0, 0, 0, 1);
    step(16'h4321, 16'h0, 1);
    step(16'h1111, 16'h0, 0); push(16'h4321, 16'h0000, "R6");
    wait_out(); chk("R6 single q", q_o, 0);

    set_mode(1, 0, 0, 0, 0);
    step(16'h0, 16'h0, 0);
    step(16'h0, 16'h0, 0);
    wait_out();
    @(negedge clk); #1;
    chk("R1 R2 missing pairs", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule